// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Generator

This block turns single-strobe internal bus requests into the pin timing of an 8-bit controller's external bus, where one port carries the high address byte and another port carries the low address byte first and the data byte later in the same cycle. It divides the input clock by four to make the E clock. E low is the address phase and E high is the data phase. An address strobe lets board logic latch the low address byte. A read/write line gives the transfer direction. An open-drain pull-down marks each opcode fetch.

The internal side presents an address, write data, a write flag and an opcode-fetch flag with a one-clock start pulse. A bus cycle begins only on an E-cycle boundary. A request raised in the middle of a cycle waits in a single pending slot. A halt input parks the bus with every clock output low. Read data is sampled as E falls and is returned with a one-clock valid pulse.

Top module: `ebus_mux_ctrl`

## Requirements
- R1: While not halted, E is low for two input clocks and then high for two input clocks. Each E cycle starts with E low.
- R2: The address strobe is high only in the first input clock of each running E cycle and is never high together with E.
- R3: The high port shows address bits 15..8 of the current cycle for the whole cycle. While E is low in a running cycle, the multiplexed port is driven (enable 1) with address bits 7..0.
- R4: In a write cycle, read/write is low for the whole cycle and the multiplexed port is driven with the write data while E is high. Consecutive write cycles keep read/write low with no high gap.
- R5: In a read cycle, read/write is high and the multiplexed port enable is 0 while E is high. The port input is sampled on the last input clock of E high and appears on the read-data output. The read-valid output pulses for the single clock that follows the fall of E.
- R6: A start pulse in any input clock of an E cycle takes effect in the next E cycle. If a second pulse arrives before that boundary, it replaces the first. If a pulse arrives while one request is already pending at the boundary, it is kept for the cycle after.
- R7: An E cycle with no request is idle. In an idle cycle read/write is high, the port is driven only while E is low, the opcode-fetch pull-down is off and no read-valid pulse follows.
- R8: The opcode-fetch pull-down output is 1 for the whole E cycle of a request flagged as an opcode fetch and 0 in every other cycle.
- R9: Halt is sampled on the last input clock of an E cycle. While parked, E, the address strobe, the port enable and the pull-down are all 0 and requests are held. One clock after halt drops, a cycle starts with the strobe high and runs the held request.
- R10: During reset the block sits at the start of an idle cycle with the strobe high, E low, read/write high, address 0 and no read-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Park the bus at the next cycle boundary |
| req_start_i | input | 1 | One-clock request pulse |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Request write data |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_opfetch_i | input | 1 | Request is an opcode fetch |
| mux_in_i | input | DATA_W | Multiplexed port pin input |
| e_o | output | 1 | E clock |
| as_o | output | 1 | Address strobe |
| rw_o | output | 1 | 1 = read, 0 = write |
| addr_hi_o | output | ADDR_W-DATA_W | High address byte port |
| mux_out_o | output | DATA_W | Multiplexed port output value |
| mux_oe_o | output | 1 | Multiplexed port output enable |
| instr_pull_o | output | 1 | Pull-down enable of the open-drain opcode-fetch line |
| rd_data_o | output | DATA_W | Captured read data |
| rd_valid_o | output | 1 | Read data valid pulse |

## Verification
The bench uses the default widths: a 16-bit address split into two 8-bit ports. At these widths every address and data byte value can be reached by random stimulus, and the high and low address bytes are checked on separate pins. A behavioural model, built on a phase counter and a one-entry queue, is compared with every output on every clock. Directed sequences cover start pulses in each phase, the replacement of a pending request, back-to-back writes, idle cycles, and halts that capture a request.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    typedef enum logic [1:0] {
        PH_ADR0 = 2'd0,
        PH_ADR1 = 2'd1,
        PH_DAT0 = 2'd2,
        PH_DAT1 = 2'd3
    } ebus_phase_e;

    typedef struct packed {
        logic valid;
        logic write;
        logic opfetch;
    } ebus_ctl_t;

    localparam ebus_ctl_t CTL_IDLE = '{valid: 1'b0, write: 1'b0, opfetch: 1'b0};

    function automatic logic phase_is_data(input ebus_phase_e ph);
        return ph == PH_DAT0 || ph == PH_DAT1;
    endfunction

    function automatic logic phase_is_last(input ebus_phase_e ph);
        return ph == PH_DAT1;
    endfunction

endpackage

// File: rtl/ebus_phase_gen.sv
module ebus_phase_gen
    import ebus_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        halt_i,
    output ebus_phase_e phase_o,
    output logic        parked_o,
    output logic        load_o,
    output logic        park_o
);
    ebus_phase_e phase_q;
    logic        parked_q;

    always_comb begin
        load_o = !halt_i && (parked_q || phase_is_last(phase_q));
        park_o = halt_i && !parked_q && phase_is_last(phase_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_ADR0;
            parked_q <= 1'b0;
        end else if (park_o) begin
            phase_q  <= PH_ADR0;
            parked_q <= 1'b1;
        end else if (load_o) begin
            phase_q  <= PH_ADR0;
            parked_q <= 1'b0;
        end else if (!parked_q) begin
            phase_q  <= ebus_phase_e'(phase_q + 2'd1);
        end
    end

    assign phase_o  = phase_q;
    assign parked_o = parked_q;
endmodule

// File: rtl/ebus_req_slot.sv
module ebus_req_slot
    import ebus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              req_write_i,
    input  logic              req_opfetch_i,
    input  logic              load_i,
    input  logic              park_i,
    output ebus_ctl_t         act_ctl_o,
    output logic [ADDR_W-1:0] act_addr_o,
    output logic [DATA_W-1:0] act_wdata_o
);
    ebus_ctl_t         pend_ctl_q, act_ctl_q, new_ctl;
    logic [ADDR_W-1:0] pend_addr_q, act_addr_q;
    logic [DATA_W-1:0] pend_wdata_q, act_wdata_q;

    always_comb begin
        new_ctl.valid   = 1'b1;
        new_ctl.write   = req_write_i;
        new_ctl.opfetch = req_opfetch_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_ctl_q   <= CTL_IDLE;
            pend_addr_q  <= '0;
            pend_wdata_q <= '0;
            act_ctl_q    <= CTL_IDLE;
            act_addr_q   <= '0;
            act_wdata_q  <= '0;
        end else if (load_i) begin
            if (pend_ctl_q.valid) begin
                act_ctl_q   <= pend_ctl_q;
                act_addr_q  <= pend_addr_q;
                act_wdata_q <= pend_wdata_q;
                pend_ctl_q  <= req_start_i ? new_ctl : CTL_IDLE;
                if (req_start_i) begin
                    pend_addr_q  <= req_addr_i;
                    pend_wdata_q <= req_wdata_i;
                end
            end else if (req_start_i) begin
                act_ctl_q   <= new_ctl;
                act_addr_q  <= req_addr_i;
                act_wdata_q <= req_wdata_i;
            end else begin
                act_ctl_q   <= CTL_IDLE;
            end
        end else begin
            if (park_i) act_ctl_q <= CTL_IDLE;
            if (req_start_i) begin
                pend_ctl_q   <= new_ctl;
                pend_addr_q  <= req_addr_i;
                pend_wdata_q <= req_wdata_i;
            end
        end
    end

    assign act_ctl_o   = act_ctl_q;
    assign act_addr_o  = act_addr_q;
    assign act_wdata_o = act_wdata_q;
endmodule

// File: rtl/ebus_pin_mux.sv
module ebus_pin_mux
    import ebus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ebus_phase_e       phase_i,
    input  logic              parked_i,
    input  ebus_ctl_t         act_ctl_i,
    input  logic [ADDR_W-1:0] act_addr_i,
    input  logic [DATA_W-1:0] act_wdata_i,
    input  logic [DATA_W-1:0] mux_in_i,
    output logic              e_o,
    output logic              as_o,
    output logic              rw_o,
    output logic [HI_W-1:0]   addr_hi_o,
    output logic [DATA_W-1:0] mux_out_o,
    output logic              mux_oe_o,
    output logic              instr_pull_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);
    logic              data_ph, is_wr;
    logic [DATA_W-1:0] rd_data_q;
    logic              rd_valid_q;

    always_comb begin
        data_ph      = phase_is_data(phase_i);
        is_wr        = act_ctl_i.valid && act_ctl_i.write;
        e_o          = !parked_i && data_ph;
        as_o         = !parked_i && (phase_i == PH_ADR0);
        rw_o         = !is_wr;
        addr_hi_o    = act_addr_i[ADDR_W-1:DATA_W];
        mux_out_o    = data_ph ? act_wdata_i : act_addr_i[DATA_W-1:0];
        mux_oe_o     = !parked_i && (!data_ph || is_wr);
        instr_pull_o = !parked_i && act_ctl_i.valid && act_ctl_i.opfetch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            if (!parked_i && phase_is_last(phase_i) && act_ctl_i.valid && !act_ctl_i.write) begin
                rd_data_q  <= mux_in_i;
                rd_valid_q <= 1'b1;
            end
        end
    end

    assign rd_data_o  = rd_data_q;
    assign rd_valid_o = rd_valid_q;
endmodule

// File: rtl/ebus_mux_ctrl.sv
module ebus_mux_ctrl
    import ebus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt_i,
    input  logic              req_start_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              req_write_i,
    input  logic              req_opfetch_i,
    input  logic [DATA_W-1:0] mux_in_i,
    output logic              e_o,
    output logic              as_o,
    output logic              rw_o,
    output logic [HI_W-1:0]   addr_hi_o,
    output logic [DATA_W-1:0] mux_out_o,
    output logic              mux_oe_o,
    output logic              instr_pull_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);
    ebus_phase_e       phase;
    logic              parked, load, park;
    ebus_ctl_t         act_ctl;
    logic [ADDR_W-1:0] act_addr;
    logic [DATA_W-1:0] act_wdata;

    ebus_phase_gen u_phase (
        .clk(clk), .rst(rst), .halt_i(halt_i),
        .phase_o(phase), .parked_o(parked), .load_o(load), .park_o(park)
    );

    ebus_req_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
        .clk(clk), .rst(rst),
        .req_start_i(req_start_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .req_write_i(req_write_i), .req_opfetch_i(req_opfetch_i),
        .load_i(load), .park_i(park),
        .act_ctl_o(act_ctl), .act_addr_o(act_addr), .act_wdata_o(act_wdata)
    );

    ebus_pin_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk(clk), .rst(rst), .phase_i(phase), .parked_i(parked),
        .act_ctl_i(act_ctl), .act_addr_i(act_addr), .act_wdata_i(act_wdata),
        .mux_in_i(mux_in_i),
        .e_o(e_o), .as_o(as_o), .rw_o(rw_o), .addr_hi_o(addr_hi_o),
        .mux_out_o(mux_out_o), .mux_oe_o(mux_oe_o), .instr_pull_o(instr_pull_o),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
    );

    // R1
    e_low_before_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(e_o) |-> !$past(e_o, 2));

    // R2
    as_apart_from_e_chk: assert property (@(posedge clk) disable iff (rst)
        as_o |-> !e_o);

    // R4
    drive_in_data_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        (e_o && mux_oe_o) |-> !rw_o);

    // R4
    rw_steady_in_data_chk: assert property (@(posedge clk) disable iff (rst)
        (e_o && $past(e_o)) |-> $stable(rw_o));

    // R5
    rd_valid_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> (!e_o && $past(e_o)));
endmodule

// File: tb/ebus_mux_ctrl_tb.sv
module ebus_mux_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halt_i = 1'b0;
    logic        req_start_i = 1'b0;
    logic [15:0] req_addr_i = '0;
    logic [7:0]  req_wdata_i = '0;
    logic        req_write_i = 1'b0;
    logic        req_opfetch_i = 1'b0;
    logic [7:0]  mux_in_i = 8'h5A;
    logic        e_o, as_o, rw_o, mux_oe_o, instr_pull_o, rd_valid_o;
    logic [7:0]  addr_hi_o, mux_out_o, rd_data_o;

    int checks = 0;
    int errors = 0;
    string scen = "R10";

    always #10 clk = ~clk;

    ebus_mux_ctrl dut_i (
        .clk(clk), .rst(rst), .halt_i(halt_i), .req_start_i(req_start_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_write_i(req_write_i),
        .req_opfetch_i(req_opfetch_i), .mux_in_i(mux_in_i),
        .e_o(e_o), .as_o(as_o), .rw_o(rw_o), .addr_hi_o(addr_hi_o),
        .mux_out_o(mux_out_o), .mux_oe_o(mux_oe_o), .instr_pull_o(instr_pull_o),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
    );

    // behavioural model
    int          m_ph = 0;
    bit          m_st = 0, m_v = 0, m_w = 0, m_op = 0, m_rdv = 0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_wd = '0, m_rdd = '0;
    logic [25:0] pq[$];

    function automatic logic [25:0] pack_req();
        return {req_opfetch_i, req_write_i, req_wdata_i, req_addr_i};
    endfunction

    task automatic take(input logic [25:0] x);
        m_v = 1; m_op = x[25]; m_w = x[24]; m_wd = x[23:16]; m_addr = x[15:0];
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_st = 0; m_v = 0; m_w = 0; m_op = 0; m_rdv = 0;
            m_addr = '0; m_wd = '0; m_rdd = '0; pq.delete();
        end else begin
            if (!m_st && m_ph == 3 && m_v && !m_w) begin m_rdv = 1; m_rdd = mux_in_i; end
            else m_rdv = 0;
            if (!m_st && m_ph == 3 && halt_i) begin
                m_st = 1; m_ph = 0; m_v = 0;
                if (req_start_i) begin pq.delete(); pq.push_back(pack_req()); end
            end else if (m_st && halt_i) begin
                if (req_start_i) begin pq.delete(); pq.push_back(pack_req()); end
            end else if (m_st || m_ph == 3) begin
                m_st = 0; m_ph = 0;
                if (pq.size() > 0) begin
                    take(pq.pop_front());
                    if (req_start_i) pq.push_back(pack_req());
                end else if (req_start_i) take(pack_req());
                else m_v = 0;
            end else begin
                m_ph = m_ph + 1;
                if (req_start_i) begin pq.delete(); pq.push_back(pack_req()); end
            end
        end
    end

    task automatic chk(input string rq, input string sig, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) %s: actual %h expected %h at %0t", rq, scen, sig, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            logic x_oe;
            x_oe = !m_st && (m_ph < 2 || (m_v && m_w));
            chk("R1", "e", 16'(e_o), 16'(!m_st && m_ph >= 2));
            chk("R2", "as", 16'(as_o), 16'(!m_st && m_ph == 0));
            chk("R3", "addr_hi", 16'(addr_hi_o), 16'(m_addr[15:8]));
            chk("R4", "oe", 16'(mux_oe_o), 16'(x_oe));
            if (x_oe) chk("R3", "mux", 16'(mux_out_o), 16'(m_ph < 2 ? m_addr[7:0] : m_wd));
            chk("R4", "rw", 16'(rw_o), 16'(!(m_v && m_w)));
            chk("R8", "pull", 16'(instr_pull_o), 16'(!m_st && m_v && m_op));
            chk("R5", "rd_valid", 16'(rd_valid_o), 16'(m_rdv));
            if (m_rdv) chk("R5", "rd_data", 16'(rd_data_o), 16'(m_rdd));
        end
    end

    always @(negedge clk) mux_in_i <= mux_in_i * 8'd5 + 8'd37;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ph(input int p);
        @(negedge clk);
        while (m_st || m_ph != p) @(negedge clk);
    endtask

    task automatic issue(input logic [15:0] a, input logic [7:0] d, input bit wr, input bit op);
        req_start_i = 1; req_addr_i = a; req_wdata_i = d; req_write_i = wr; req_opfetch_i = op;
        @(negedge clk);
        req_start_i = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        scen = "R10";
        chk("R10", "as", 16'(as_o), 16'd1);
        chk("R10", "e", 16'(e_o), 16'd0);
        chk("R10", "rw", 16'(rw_o), 16'd1);
        chk("R10", "addr_hi", 16'(addr_hi_o), 16'd0);
        chk("R10", "rd_valid", 16'(rd_valid_o), 16'd0);
        rst = 0;
        scen = "R5"; wait_ph(3); issue(16'hC123, 8'h00, 0, 1); step(8);
        scen = "R4"; wait_ph(3); issue(16'h4A10, 8'h99, 1, 0);
        wait_ph(1); issue(16'h4A11, 8'h77, 1, 0); step(10);
        scen = "R6"; wait_ph(1); issue(16'h1111, 8'h11, 1, 0); issue(16'h2222, 8'h22, 0, 0); step(8);
        wait_ph(3); issue(16'h3333, 8'h33, 0, 1); issue(16'h4444, 8'h44, 1, 0); step(10);
        scen = "R7"; step(12);
        scen = "R9"; halt_i = 1; step(6); issue(16'hBEEF, 8'h5C, 1, 1); step(5); halt_i = 0; step(10);
        wait_ph(2); halt_i = 1; issue(16'h0F0F, 8'h00, 0, 0); step(6); halt_i = 0; step(8);
        scen = "R1";
        for (int i = 0; i < 600; i++) begin
            halt_i = ($urandom % 16) == 0;
            req_start_i = ($urandom % 3) == 0;
            req_addr_i = 16'($urandom); req_wdata_i = 8'($urandom);
            req_write_i = 1'($urandom); req_opfetch_i = 1'($urandom);
            @(negedge clk);
        end
        req_start_i = 0; halt_i = 0; step(8);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule